// File: doc/BRIEF.md
# Reset Cause Collector

This block gathers every reset request in the chip into one stretched system reset. It also keeps a readable record of which requests took part in the most recent reset. The requests come from these sources:

- power-on
- the external reset pin
- a watchdog timeout
- clock loss
- low supply voltage
- wakeup from deep low-power stop
- a software request
- core lockup
- the flash-programming port
- a debug-port system request

Power-on works as an asynchronous clear of all state. After a power-on, the record always shows both the power-on cause and the low-voltage cause.

A low-voltage condition holds the system in reset until the supply-good indication comes back. The flash-programming port and the debug-port request reset the system but leave no trace in the record.

A separate test-reset input is synchronized and passed out as its own debug reset. It does not touch the system reset or the record. Three groups of inputs are treated differently:

- The pin, low-voltage, supply-good, wakeup and test-reset inputs are asynchronous. Each passes through a two-stage synchronizer.
- All other requests are synchronous to the clock.
- Power-on is asynchronous and acts directly as the clear.

Top module: `rst_cause_hub`

## Requirements
- R1: Any synchronous request (watchdog, clock loss, software, lockup, flash port, debug port) makes `sys_rst_o` high after the next rising clock edge.
- R2: After the last request is gone, `sys_rst_o` stays high for exactly STRETCH (default 16) sampled cycles and then falls. For a synchronous source this counts from the first edge that sees the request low.
- R3: `cause_o` bit positions: 0 power-on, 1 pin, 2 watchdog, 3 clock loss, 4 low voltage, 5 wakeup, 6 software, 7 lockup.
- R4: A reset event caused only by the flash port or the debug-port request leaves `cause_o` at 0x00.
- R5: While `por_i` is high, `sys_rst_o` is 1 and `cause_o` is 0x11, with no clock edge needed.
- R6: While the low-voltage hold is set, `sys_rst_o` stays high. The hold is set by power-on or by `lowv_i`. It clears only once the synchronized `supply_ok_i` is high and `lowv_i` is low.
- R7: When a new event starts (`sys_rst_o` low and a request appears), `cause_o` is replaced by the set of active sources. Further sources that appear while `sys_rst_o` is high are added, so several bits can be set together.
- R8: While `sys_rst_o` is low and no request is active, `cause_o` holds its value.
- R9: `test_rst_i` reaches `dbg_rst_o` after SYNC_STAGES edges and changes neither `sys_rst_o` nor `cause_o`.
- R10: The pin, wakeup and low-voltage requests pass through SYNC_STAGES flops, so each adds SYNC_STAGES cycles to assertion and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, asynchronous clear, active high |
| pin_rst_i | input | 1 | External pin reset request (async) |
| wdog_i | input | 1 | Watchdog timeout request |
| clkloss_i | input | 1 | Clock loss request |
| lowv_i | input | 1 | Supply below low threshold (async level) |
| supply_ok_i | input | 1 | Supply-good indication (async level) |
| wake_i | input | 1 | Deep-stop wakeup request (async) |
| swreq_i | input | 1 | Software reset request |
| lockup_i | input | 1 | Core lockup request |
| flashport_i | input | 1 | Flash-programming port request (no cause bit) |
| dbgport_i | input | 1 | Debug-port system reset request (no cause bit) |
| test_rst_i | input | 1 | Test reset input (async), feeds only the debug reset |
| sys_rst_o | output | 1 | Stretched system reset |
| dbg_rst_o | output | 1 | Synchronized debug reset |
| cause_o | output | 8 | Reset cause record, bit map per R3 |

## Verification
The assertions assume two things about the inputs. First, every request listed as synchronous is already clean in the clock domain. Second, power-on is asserted at time zero, so every flop starts from a known value. The bench drives all inputs on the falling edge and asserts power-on before the first rising edge. It holds each asynchronous request for at least three cycles, so the two-stage synchronizer cannot miss it. Between stimuli it waits until the reset has fully released, so every event it checks starts from a quiet state.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int CAUSE_W   = 8;
  localparam int CB_POR    = 0;
  localparam int CB_PIN    = 1;
  localparam int CB_WDOG   = 2;
  localparam int CB_CLK    = 3;
  localparam int CB_LVD    = 4;
  localparam int CB_WAKE   = 5;
  localparam int CB_SW     = 6;
  localparam int CB_LOCKUP = 7;
  localparam logic [CAUSE_W-1:0] POR_CAUSE =
    CAUSE_W'((1 << CB_POR) | (1 << CB_LVD));
  // indices into the asynchronous input bank
  localparam int AS_PIN  = 0;
  localparam int AS_LOWV = 1;
  localparam int AS_SUP  = 2;
  localparam int AS_WAKE = 3;
  localparam int AS_TEST = 4;
  localparam int AS_N    = 5;
endpackage

// File: rtl/rch_sync.sv
module rch_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) stg[0] <= '0;
    else       stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or posedge clr_i) begin
      if (clr_i) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rch_stretch.sv
module rch_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic act_i,
  output logic rst_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      cnt   <= LOAD;
      rst_q <= 1'b1;
    end else if (act_i) begin
      cnt   <= LOAD;
      rst_q <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      rst_q <= 1'b1;
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign rst_o = rst_q;

  p_req_sets_rst_r1: assert property (@(posedge clk_i) disable iff (clr_i)
    act_i |=> rst_q);
  p_fall_after_quiet_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    $fell(rst_q) |-> !$past(act_i));
endmodule

// File: rtl/rch_status.sv
module rch_status
  import rst_cause_pkg::*;
(
  input  logic               clk_i,
  input  logic               clr_i,
  input  logic               in_rst_i,
  input  logic               act_i,
  input  logic [CAUSE_W-1:0] src_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i)                 cause_q <= POR_CAUSE;
    else if (!in_rst_i && act_i) cause_q <= src_i;
    else if (in_rst_i)         cause_q <= cause_q | src_i;
  end

  assign cause_o = cause_q;

  p_new_event_load_r7: assert property (@(posedge clk_i) disable iff (clr_i)
    (!in_rst_i && act_i) |=> (cause_o == $past(src_i)));
  p_hold_when_idle_r8: assert property (@(posedge clk_i) disable iff (clr_i)
    (!in_rst_i && !act_i) |=> $stable(cause_o));
endmodule

// File: rtl/rst_cause_hub.sv
module rst_cause_hub
  import rst_cause_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 16
) (
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               pin_rst_i,
  input  logic               wdog_i,
  input  logic               clkloss_i,
  input  logic               lowv_i,
  input  logic               supply_ok_i,
  input  logic               wake_i,
  input  logic               swreq_i,
  input  logic               lockup_i,
  input  logic               flashport_i,
  input  logic               dbgport_i,
  input  logic               test_rst_i,
  output logic               sys_rst_o,
  output logic               dbg_rst_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [AS_N-1:0]    as_raw, as_s;
  logic               lvd_hold;
  logic               any_act;
  logic [CAUSE_W-1:0] src;

  always_comb begin
    as_raw          = '0;
    as_raw[AS_PIN]  = pin_rst_i;
    as_raw[AS_LOWV] = lowv_i;
    as_raw[AS_SUP]  = supply_ok_i;
    as_raw[AS_WAKE] = wake_i;
    as_raw[AS_TEST] = test_rst_i;
  end

  rch_sync #(.W(AS_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .clr_i (por_i),
    .d_i   (as_raw),
    .q_o   (as_s)
  );

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)              lvd_hold <= 1'b1;
    else if (as_s[AS_LOWV]) lvd_hold <= 1'b1;
    else if (as_s[AS_SUP])  lvd_hold <= 1'b0;
  end

  always_comb begin
    src            = '0;
    src[CB_PIN]    = as_s[AS_PIN];
    src[CB_WDOG]   = wdog_i;
    src[CB_CLK]    = clkloss_i;
    src[CB_LVD]    = lvd_hold | as_s[AS_LOWV];
    src[CB_WAKE]   = as_s[AS_WAKE];
    src[CB_SW]     = swreq_i;
    src[CB_LOCKUP] = lockup_i;
    any_act        = (|src) | flashport_i | dbgport_i;
  end

  rch_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk_i (clk_i),
    .clr_i (por_i),
    .act_i (any_act),
    .rst_o (sys_rst_o)
  );

  rch_status u_status (
    .clk_i    (clk_i),
    .clr_i    (por_i),
    .in_rst_i (sys_rst_o),
    .act_i    (any_act),
    .src_i    (src),
    .cause_o  (cause_o)
  );

  assign dbg_rst_o = as_s[AS_TEST];

  p_lvd_holds_reset_r6: assert property (@(posedge clk_i) disable iff (por_i)
    (lvd_hold && !as_s[AS_SUP]) |=> sys_rst_o);
  p_test_isolated_r9: assert property (@(posedge clk_i) disable iff (por_i)
    ($rose(dbg_rst_o) && !sys_rst_o && !any_act) |=> !sys_rst_o);
endmodule

// File: tb/sim_rst_cause_hub.sv
module sim_rst_cause_hub;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por, pin, wdog, clkl, lowv, sup, wake, sw, lock, flash, dbgp, trst;
  logic sys_rst, dbg_rst;
  logic [7:0] cause;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_hub u0 (
    .clk_i(clk), .por_i(por), .pin_rst_i(pin), .wdog_i(wdog), .clkloss_i(clkl),
    .lowv_i(lowv), .supply_ok_i(sup), .wake_i(wake), .swreq_i(sw),
    .lockup_i(lock), .flashport_i(flash), .dbgport_i(dbgp), .test_rst_i(trst),
    .sys_rst_o(sys_rst), .dbg_rst_o(dbg_rst), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // source index: 0 pin,1 wdog,2 clkloss,3 lowv,4 wake,5 sw,6 lockup,7 flash,8 dbgport
  task automatic set_req(input int idx, input logic v);
    case (idx)
      0: pin = v;  1: wdog = v; 2: clkl = v; 3: lowv = v; 4: wake = v;
      5: sw = v;   6: lock = v; 7: flash = v; default: dbgp = v;
    endcase
  endtask

  function automatic int exp_cause(input int idx);
    // R3 bit map: pin1 wdog2 clk3 lvd4 wake5 sw6 lockup7; flash/dbgport none (R4)
    if (idx <= 6) return 1 << (idx + 1);
    return 0;
  endfunction

  function automatic int exp_hold(input int idx);
    // R2 base stretch 16; R10 two sync stages for pin/wake, lowv one more for hold clear
    if (idx == 0 || idx == 4) return 18;
    if (idx == 3) return 19;
    return 16;
  endfunction

  task automatic count_high(output int n);
    n = 0;
    while (n < 100) begin
      @(posedge clk); @(negedge clk);
      if (sys_rst) n++; else break;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    int n;
    {pin, wdog, clkl, lowv, sup, wake, sw, lock, flash, dbgp, trst} = '0;
    por = 1'b1;
    #1;
    chk("R5 por sys_rst", sys_rst, 1);
    chk("R5 por cause", cause, 8'h11);
    cyc(3);
    @(negedge clk); por = 1'b0;
    cyc(40);
    chk("R6 held without supply_ok", sys_rst, 1);
    sup = 1'b1;
    cyc(40);
    chk("R6 released after supply_ok", sys_rst, 0);
    chk("R5 cause after power-on", cause, 8'h11);

    for (int i = 0; i < 9; i++) begin
      set_req(i, 1'b1);
      cyc(3);
      chk($sformatf("R1/R10 src%0d asserts", i), sys_rst, 1);
      set_req(i, 1'b0);
      count_high(n);
      chk($sformatf("R2/R10 src%0d stretch", i), n, exp_hold(i));
      chk($sformatf("R3/R4 src%0d cause", i), cause, exp_cause(i));
      cyc(5);
    end

    // R1 exact latency for a synchronous source
    wdog = 1'b1;
    cyc(1);
    chk("R1 one-edge latency", sys_rst, 1);
    wdog = 1'b0;
    cyc(25);

    // R7 multi-source event, then replacement
    wdog = 1'b1; sw = 1'b1;
    cyc(2);
    wdog = 1'b0; sw = 1'b0;
    cyc(5);
    lock = 1'b1;
    cyc(1);
    lock = 1'b0;
    cyc(30);
    chk("R7 multi plus late source", cause, 8'hC4);
    chk("R8 idle keeps cause", cause, 8'hC4);
    pin = 1'b1;
    cyc(4);
    pin = 1'b0;
    cyc(30);
    chk("R7 new event replaces", cause, 8'h02);

    // R6 low-voltage with supply lost
    sup = 1'b0; lowv = 1'b1;
    cyc(4);
    lowv = 1'b0;
    cyc(40);
    chk("R6 held until supply_ok", sys_rst, 1);
    sup = 1'b1;
    cyc(40);
    chk("R6 released", sys_rst, 0);
    chk("R6 lvd cause", cause, 8'h10);

    // R9 test reset isolated
    trst = 1'b1;
    cyc(1);
    chk("R9 dbg not yet", dbg_rst, 0);
    cyc(1);
    chk("R9 dbg after sync", dbg_rst, 1);
    cyc(5);
    chk("R9 sys_rst untouched", sys_rst, 0);
    chk("R9 cause untouched", cause, 8'h10);
    trst = 1'b0;
    cyc(4);
    chk("R9 dbg release", dbg_rst, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule